// File: doc/BRIEF.md
# Supervisor Trap and Interrupt Controller

This block owns the processor status word and decides, every cycle, whether the core must leave its instruction stream. A synchronous trap request from the pipeline, or a pending and enabled interrupt line, starts trap entry. Trap entry moves the core into supervisor mode and clears the global interrupt enable. It keeps one level of history for the previous mode and the previous enable. It latches a cause value and the faulting program counter, tells the memory side to drop any load reservation, and asserts a one-cycle redirect to the exception vector.

Interrupt lines are level inputs. Each line is copied into a pending field of the status word that software cannot overwrite. An interrupt is takeable when its pending bit and its mask bit are both set and the global enable is on. The lowest-numbered takeable line wins. Its cause value is the line number with a single high marker bit. That marker is bit 63 in 64-bit supervisor mode and bit 31 otherwise.

After reset the redirect address holds the boot address 0x2000. The core is in supervisor mode, both 64-bit mode bits are set, and interrupts and translation are off.

Top module: `stc_trap_ctrl`

## Requirements
- R1: After reset, status equals 0x34 (supervisor bit 2, supervisor-64 bit 4, user-64 bit 5; enable bit 0 and translation bit 6 clear). redirect_pc is 0x2000. redirect_valid, resv_drop, cause and epc are zero.
- R2: Status bits 31:24 form the pending field. Each clock edge copies irq_lines into it, which sets or clears each bit to follow its line.
- R3: A status write (stat_we) with no trap in the same cycle loads stat_wdata into every bit except 31:24. Those bits keep the hardware pending value.
- R4: An interrupt is taken only when (pending bits 31:24 AND mask bits 23:16) is non-zero and the enable bit 0 is set. Otherwise no redirect occurs and status does not change from the interrupt.
- R5: Among takeable interrupts the lowest-numbered line is taken. Its cause value is the line index plus a single set marker bit.
- R6: The interrupt marker bit is bit 63 when the supervisor-64 bit 4 is set, and bit 31 when it is clear.
- R7: On trap entry, status bit 2 is set and bit 0 is cleared. Bit 3 receives the old bit 2 and bit 1 receives the old bit 0. All other bits are unchanged.
- R8: On trap entry, the next cycle shows the following: cause holds the trap cause, epc holds trap_pc, redirect_pc holds the exception vector, and redirect_valid and resv_drop are high for exactly that one cycle.
- R9: A write to the exception vector stores evec_wdata with its two low bits forced to zero.
- R10: A trap request takes priority over a takeable interrupt and over a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Synchronous trap request from the pipeline |
| trap_cause | input | XLEN | Cause value of the requested trap |
| trap_pc | input | XLEN | Program counter of the trapping instruction |
| irq_lines | input | NIRQ | Level interrupt lines (timer, inter-processor, host, ...) |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | XLEN | Status register write data |
| evec_we | input | 1 | Exception vector write strobe |
| evec_wdata | input | XLEN | Exception vector write data |
| status | output | XLEN | Current status word |
| redirect_valid | output | 1 | One-cycle pulse: fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Restart address (boot address after reset) |
| epc | output | XLEN | Saved exception program counter |
| cause | output | XLEN | Latched trap or interrupt cause |
| resv_drop | output | 1 | One-cycle pulse: discard any load reservation |

## Verification
The bound checker checks several rules on every cycle. The pending field always mirrors the previous cycle's lines. The redirect address is always word aligned. A redirect always leaves the core in supervisor mode with interrupts off. A trap request always copies mode and enable into the history bits and latches its own cause and PC. No redirect happens while interrupts are disabled and no trap is requested. Two behaviours depend on how the pending, mask and mode bits combine, and only the bench sweeps show them. These are which line wins among several takeable ones, and where the cause marker lands. The same holds for the exact result of a status write against live pending bits.

// File: rtl/stc_pkg.sv
// Shared bit positions of the status word.
// Assumes the pending and mask fields sit above bit 6 (set by parameters in the top).
package stc_pkg;
    localparam int ST_EI  = 0;  // global interrupt enable
    localparam int ST_PEI = 1;  // enable before the last trap
    localparam int ST_S   = 2;  // supervisor mode
    localparam int ST_PS  = 3;  // mode before the last trap
    localparam int ST_S64 = 4;  // 64-bit supervisor mode
    localparam int ST_U64 = 5;  // 64-bit user mode
    localparam int ST_VM  = 6;  // address translation enable
endpackage

// File: rtl/stc_irq_select.sv
// Interrupt selector: combines pending and mask bits, applies the global enable,
// picks the lowest-numbered takeable line and forms its cause value.
// Assumes XLEN >= 32 so that the 32-bit marker position exists.
module stc_irq_select #(
    parameter int XLEN = 64,
    parameter int NIRQ = 8
) (
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] mask,
    input  logic            glob_en,
    input  logic            wide_mode,
    output logic            take,
    output logic [XLEN-1:0] irq_cause
);
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [NIRQ-1:0] ready;
    logic [IW-1:0]   win_idx;

    // Purpose: find the lowest-numbered line that is both pending and unmasked.
    always_comb begin
        ready   = pend & mask;
        win_idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (ready[i]) win_idx = IW'(i);
        end
    end

    // Purpose: gate by global enable and place the marker bit by current width.
    always_comb begin
        take      = glob_en && (ready != '0);
        irq_cause = XLEN'(win_idx);
        if (wide_mode) irq_cause[XLEN-1] = 1'b1;
        else           irq_cause[31]     = 1'b1;
    end
endmodule

// File: rtl/stc_status_reg.sv
// Status word register: applies trap entry or a software write, then overlays
// the pending field with the current interrupt lines.
// Assumes trap entry and software write are never applied together (trap wins).
module stc_status_reg
    import stc_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NIRQ    = 8,
    parameter int PEND_SH = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_trap,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic [NIRQ-1:0] irq_lines,
    output logic [XLEN-1:0] status
);
    localparam logic [XLEN-1:0] PEND_FIELD =
        XLEN'({NIRQ{1'b1}}) << PEND_SH;
    localparam logic [XLEN-1:0] BOOT_STATUS =
        (XLEN'(1) << ST_S) | (XLEN'(1) << ST_S64) | (XLEN'(1) << ST_U64);

    logic [XLEN-1:0] nxt;

    // Purpose: compute the next status word by priority, then overlay pending bits.
    always_comb begin
        nxt = status;
        if (enter_trap) begin
            nxt[ST_S]   = 1'b1;
            nxt[ST_EI]  = 1'b0;
            nxt[ST_PS]  = status[ST_S];
            nxt[ST_PEI] = status[ST_EI];
        end else if (wr_en) begin
            nxt = wr_data;
        end
        nxt = (nxt & ~PEND_FIELD) | ((XLEN'(irq_lines) << PEND_SH) & PEND_FIELD);
    end

    // Purpose: hold the status word; reset into the boot privilege state.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= BOOT_STATUS;
        else        status <= nxt;
    end
endmodule

// File: rtl/stc_trap_regs.sv
// Trap bookkeeping registers: exception vector, saved PC, cause, and the
// one-cycle redirect and reservation-drop pulses.
// Assumes 'enter' is already the resolved trap-or-interrupt decision.
module stc_trap_regs #(
    parameter int              XLEN    = 64,
    parameter logic [XLEN-1:0] BOOT_PC = 64'h2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic [XLEN-1:0] enter_cause,
    input  logic [XLEN-1:0] enter_pc,
    input  logic            evec_we,
    input  logic [XLEN-1:0] evec_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic            resv_drop
);
    logic [XLEN-1:0] evec;

    // Purpose: store the exception vector with word alignment enforced.
    always_ff @(posedge clk) begin
        if (!rst_n)       evec <= '0;
        else if (evec_we) evec <= {evec_wdata[XLEN-1:2], 2'b00};
    end

    // Purpose: latch cause and PC on trap entry and pulse the redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            resv_drop      <= 1'b0;
            redirect_pc    <= BOOT_PC;
            epc            <= '0;
            cause          <= '0;
        end else begin
            redirect_valid <= enter;
            resv_drop      <= enter;
            if (enter) begin
                redirect_pc <= evec;
                epc         <= enter_pc;
                cause       <= enter_cause;
            end
        end
    end
endmodule

// File: rtl/stc_trap_ctrl.sv
// Top of the supervisor trap and interrupt controller.
// Resolves synchronous traps against interrupts (trap first) and wires the
// status register, the interrupt selector and the trap registers together.
// Assumes XLEN >= 32 and pending/mask fields that fit inside XLEN.
module stc_trap_ctrl
    import stc_pkg::*;
#(
    parameter int              XLEN    = 64,
    parameter int              NIRQ    = 8,
    parameter int              PEND_SH = 24,
    parameter int              MASK_SH = 16,
    parameter logic [XLEN-1:0] BOOT_PC = 64'h2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [NIRQ-1:0] irq_lines,
    input  logic            stat_we,
    input  logic [XLEN-1:0] stat_wdata,
    input  logic            evec_we,
    input  logic [XLEN-1:0] evec_wdata,
    output logic [XLEN-1:0] status,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic            resv_drop
);
    logic            irq_take;
    logic [XLEN-1:0] irq_cause;
    logic            enter;
    logic [XLEN-1:0] enter_cause;

    stc_irq_select #(.XLEN(XLEN), .NIRQ(NIRQ)) u_sel (
        .pend      (status[PEND_SH +: NIRQ]),
        .mask      (status[MASK_SH +: NIRQ]),
        .glob_en   (status[ST_EI]),
        .wide_mode (status[ST_S64]),
        .take      (irq_take),
        .irq_cause (irq_cause)
    );

    // Purpose: synchronous trap outranks any interrupt in the same cycle.
    always_comb begin
        enter       = trap_req || irq_take;
        enter_cause = trap_req ? trap_cause : irq_cause;
    end

    stc_status_reg #(.XLEN(XLEN), .NIRQ(NIRQ), .PEND_SH(PEND_SH)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_trap (enter),
        .wr_en      (stat_we),
        .wr_data    (stat_wdata),
        .irq_lines  (irq_lines),
        .status     (status)
    );

    stc_trap_regs #(.XLEN(XLEN), .BOOT_PC(BOOT_PC)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .enter          (enter),
        .enter_cause    (enter_cause),
        .enter_pc       (trap_pc),
        .evec_we        (evec_we),
        .evec_wdata     (evec_wdata),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .epc            (epc),
        .cause          (cause),
        .resv_drop      (resv_drop)
    );
endmodule

// File: rtl/stc_trap_ctrl_checker.sv
// Property checker for stc_trap_ctrl, attached by bind below.
// Assumes the bit layout of stc_pkg and the top's pending-field position.
module stc_trap_ctrl_checker #(
    parameter int XLEN    = 64,
    parameter int NIRQ    = 8,
    parameter int PEND_SH = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [XLEN-1:0] trap_cause,
    input logic [XLEN-1:0] trap_pc,
    input logic [NIRQ-1:0] irq_lines,
    input logic [XLEN-1:0] status,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] epc,
    input logic [XLEN-1:0] cause
);
    // Pending field follows the lines one cycle later.
    assert_pend_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status[PEND_SH +: NIRQ] == $past(irq_lines));

    // Redirect target is always word aligned.
    assert_vec_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_pc[1:0] == 2'b00);

    // A redirect leaves the core privileged with interrupts off.
    assert_entry_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (status[2] && !status[0]));

    // A trap request copies mode and enable into the history bits.
    assert_history_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (status[3] == $past(status[2])) && (status[1] == $past(status[0])));

    // Interrupts disabled and no trap: no redirect follows.
    assert_no_irq_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !status[0]) |=> !redirect_valid);

    // A trap request wins and latches its own cause and PC.
    assert_trap_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> redirect_valid && cause == $past(trap_cause) && epc == $past(trap_pc));
endmodule

bind stc_trap_ctrl stc_trap_ctrl_checker #(
    .XLEN(XLEN), .NIRQ(NIRQ), .PEND_SH(PEND_SH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_req       (trap_req),
    .trap_cause     (trap_cause),
    .trap_pc        (trap_pc),
    .irq_lines      (irq_lines),
    .status         (status),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .cause          (cause)
);

// File: tb/stc_trap_ctrl_bench.sv
// Self-checking bench: sweeps every pending and mask pattern, plus directed
// scenarios for reset, status writes, trap entry, vector alignment and priority.
module stc_trap_ctrl_bench;
    localparam int XLEN = 64;
    localparam int NIRQ = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            trap_req;
    logic [XLEN-1:0] trap_cause;
    logic [XLEN-1:0] trap_pc;
    logic [NIRQ-1:0] irq_lines;
    logic            stat_we;
    logic [XLEN-1:0] stat_wdata;
    logic            evec_we;
    logic [XLEN-1:0] evec_wdata;
    logic [XLEN-1:0] status;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic [XLEN-1:0] epc;
    logic [XLEN-1:0] cause;
    logic            resv_drop;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    stc_trap_ctrl u_stc_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .irq_lines(irq_lines), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .evec_we(evec_we), .evec_wdata(evec_wdata),
        .status(status), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .epc(epc), .cause(cause), .resv_drop(resv_drop)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_cause(input int p, input int m, input bit s64);
        int idx = 0;
        logic [XLEN-1:0] c;
        for (int i = NIRQ - 1; i >= 0; i--) if (((p & m) >> i) & 1) idx = i;
        c = XLEN'(idx);
        if (s64) c[63] = 1'b1; else c[31] = 1'b1;
        return c;
    endfunction

    // One sweep point: quiesce, load pattern with given enable, then observe.
    task automatic run_case(input int p, input int m, input bit s64, input bit ei,
                            input string req);
        logic [XLEN-1:0] w;
        logic [XLEN-1:0] exp_st;
        bit t;
        irq_lines  = '0;
        stat_we    = 1'b1;
        stat_wdata = 64'h4;
        tick();
        stat_we = 1'b0;
        tick();
        w = (XLEN'(m) << 16) | (XLEN'(s64) << 4) | 64'h4 | XLEN'(ei);
        irq_lines  = NIRQ'(p);
        stat_we    = 1'b1;
        stat_wdata = w;
        tick();
        stat_we = 1'b0;
        tick();
        t = ei && ((p & m) != 0);
        check(req, XLEN'(redirect_valid), XLEN'(t));
        exp_st = w | (XLEN'(p) << 24);
        if (t) begin
            check(req, cause, exp_cause(p, m, s64));
            exp_st = (exp_st & ~64'h1) | 64'hE;
        end
        check({req, " status"}, status, exp_st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_cause = '0; trap_pc = '0;
        irq_lines = '0; stat_we = 1'b0; stat_wdata = '0; evec_we = 1'b0; evec_wdata = '0;
        tick(); tick();
        // R1: boot state
        check("R1 status", status, 64'h34);
        check("R1 redirect_pc", redirect_pc, 64'h2000);
        check("R1 redirect_valid", XLEN'(redirect_valid), 0);
        check("R1 resv_drop", XLEN'(resv_drop), 0);
        check("R1 cause", cause, 0);
        check("R1 epc", epc, 0);
        rst_n = 1'b1;
        tick();

        // R2: pending follows lines both ways
        irq_lines = 8'h81;
        tick();
        check("R2 set", XLEN'(status[31:24]), 64'h81);
        irq_lines = 8'h01;
        tick();
        check("R2 clear", XLEN'(status[31:24]), 64'h01);

        // R3: write cannot change pending bits
        irq_lines = 8'h5A;
        tick();
        stat_we = 1'b1;
        stat_wdata = 64'hFFFF_FFFF_A5FF_FFFE;
        tick();
        stat_we = 1'b0;
        check("R3 write", status, 64'hFFFF_FFFF_5AFF_FFFE);
        tick();
        check("R4 disabled", XLEN'(redirect_valid), 0);

        // R9/R8: aligned vector, trap latch and pulses
        irq_lines = '0;
        evec_we = 1'b1;
        evec_wdata = 64'h8000_1237;
        stat_we = 1'b1;
        stat_wdata = 64'h35;
        tick();
        evec_we = 1'b0;
        stat_we = 1'b0;
        trap_req = 1'b1; trap_cause = 64'd5; trap_pc = 64'h4444;
        tick();
        trap_req = 1'b0;
        check("R9 redirect_pc", redirect_pc, 64'h8000_1234);
        check("R8 redirect_valid", XLEN'(redirect_valid), 1);
        check("R8 resv_drop", XLEN'(resv_drop), 1);
        check("R8 cause", cause, 64'd5);
        check("R8 epc", epc, 64'h4444);
        check("R7 status", status, 64'h3E);
        tick();
        check("R8 pulse end", XLEN'(redirect_valid), 0);
        check("R8 drop end", XLEN'(resv_drop), 0);

        // R7: from user mode with enable, then back-to-back trap
        stat_we = 1'b1;
        stat_wdata = 64'h31;
        tick();
        stat_we = 1'b0;
        trap_req = 1'b1; trap_cause = 64'd2; trap_pc = 64'h10;
        tick();
        check("R7 from user", status, 64'h36);
        tick();
        trap_req = 1'b0;
        check("R7 second", status, 64'h3C);

        // R10: trap beats a takeable interrupt and a status write
        irq_lines = 8'h01;
        stat_we = 1'b1;
        stat_wdata = 64'h0001_0035;
        tick();
        stat_we = 1'b1;
        stat_wdata = '0;
        trap_req = 1'b1; trap_cause = 64'd7; trap_pc = 64'h100;
        tick();
        trap_req = 1'b0;
        stat_we = 1'b0;
        check("R10 cause", cause, 64'd7);
        check("R10 epc", epc, 64'h100);
        check("R10 status", status, 64'h0101_003E);
        tick();
        check("R10 no follow-up", XLEN'(redirect_valid), 0);

        // R5/R6: every pending pattern, both widths, all lines unmasked
        for (int p = 0; p < 256; p++) run_case(p, 8'hFF, 1'b1, 1'b1, "R5 R6 wide");
        for (int p = 0; p < 256; p++) run_case(p, 8'hFF, 1'b0, 1'b1, "R5 R6 narrow");
        // R4: every mask pattern against all-pending, then enable off
        for (int m = 0; m < 256; m++) run_case(8'hFF, m, 1'b1, 1'b1, "R4 mask");
        for (int p = 0; p < 256; p++) run_case(p, 8'hFF, 1'b1, 1'b0, "R4 enable off");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule